// File: doc/BRIEF.md
# Pipelined Fixed-Point Multiplier with Flow Control

This block multiplies two fixed-point operands and delivers the product in a separately chosen fixed-point output format. Each operand and the result have their own signedness, total width and integer width, all set by parameters. The exact product is first rescaled to the output's fraction width. Dropped fraction bits are either truncated or rounded half up. The rescaled value is then fitted into the output range. A value that does not fit is either clamped to the nearest end of the range or reduced to its low bits, and an overflow flag is raised beside it. The result then passes through a chain of `STAGES` registers, so the block behaves exactly like a combinational multiplier followed by that many registers.

A four-wire flow-control scheme links the block to its neighbours. Upstream offers data with `in_vld_i` and sees `in_rdy_o`. Downstream grants progress with `out_rdy_i` and receives `out_vld_o`. The whole register chain advances only in cycles where `out_rdy_i` is high. `in_rdy_o` acts with a one-cycle lag: data offered in the cycle after `in_rdy_o` was low is lost. A stage that holds no data is not refilled during a stall; the entire chain waits. With the default parameters, both operands and the result use a signed Q8.8 format: 16 bits in total, 8 of them integer bits, in two's complement.

Top module: `fxp_hs_mult`

## Requirements
- R1: With round-half-up selected, `prod_o` equals floor((a*b + 2^-9) * 256) / 256 in signed Q8.8. Here a and b are the operands read as signed Q8.8, and the value is in range.
- R2: With truncation selected, `prod_o` equals floor(a*b*256)/256. The dropped bits are discarded, so a negative product moves toward minus infinity.
- R3: With the saturating overflow mode, a result above +127.99609375 is output as 0x7FFF. A result below -128 is output as 0x8000.
- R4: With the wrapping overflow mode, an out-of-range result is output as the low 16 bits of the rescaled product.
- R5: `ovf_o` is high in exactly those output cycles whose rescaled product, after rounding, lies outside the output range. It is never high while `out_vld_o` is low.
- R6: Each accepted sample is presented on `out_vld_o` once exactly `STAGES` ready cycles have passed. A ready cycle is one with `out_rdy_i` high, and the count starts with the acceptance cycle. With `out_rdy_i` held high, this means `STAGES` cycles after acceptance.
- R7: In every cycle where `out_rdy_i` is low, `out_vld_o` is low. The chain holds its contents, so `prod_o` does not change. No accepted sample is lost.
- R8: `in_rdy_o` mirrors `out_rdy_i` in the same cycle. A sample is accepted only in a cycle where `in_vld_i` and `out_rdy_i` are high and `in_rdy_o` was high in the previous cycle. Reset counts as ready.
- R9: Accepted samples leave in the order they were accepted, each exactly once.
- R10: During reset and in the first cycle after it, `out_vld_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | A_W | First operand |
| b_i | input | B_W | Second operand |
| in_vld_i | input | 1 | Upstream offers an operand pair |
| out_rdy_i | input | 1 | Downstream can take a result; tie high when unused |
| in_rdy_o | output | 1 | Block can take a new pair (effective one cycle later) |
| out_vld_o | output | 1 | `prod_o` carries a result for downstream |
| prod_o | output | P_W | Product in the output format |
| ovf_o | output | 1 | The product of this result did not fit the output format |

## Verification
A stuck or mis-timed stage valid bit shows at the ports as a result that arrives a cycle early or late, or as a lost or duplicated result. The bench tracks its own count of ready cycles per sample and so catches this on the first sample affected. A wrong rounding constant or range limit shows only for specific operand pairs. Directed half-LSB and boundary cases expose it as soon as those results emerge, `STAGES` ready cycles later. A chain that keeps moving during a stall shows as a changed `prod_o`, or as a missing result once ready returns.

// File: rtl/fxp_mult_pkg.sv
// Shared mode encodings for the fixed-point multiplier.
// Assumes: consumers compare against these enum values only.
package fxp_mult_pkg;

    // What happens to a value that falls outside the output range
    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_SAT  = 1'b1
    } ovf_mode_e;

    // How discarded fraction bits are treated
    typedef enum logic {
        RND_TRUNC   = 1'b0,
        RND_HALF_UP = 1'b1
    } rnd_mode_e;

    // Larger of two integers, used for width sizing
    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/fxp_mul_core.sv
// Full-precision multiply of two fixed-point words.
// Each operand is widened by one bit (sign or zero) so signed and unsigned
// operands share a single signed multiplier; the product is exact.
// Assumes: A_W, B_W >= 1.
module fxp_mul_core #(
    parameter int A_W      = 16,
    parameter bit A_SIGNED = 1'b1,
    parameter int B_W      = 16,
    parameter bit B_SIGNED = 1'b1,
    localparam int FW      = A_W + B_W + 2
) (
    input  logic [A_W-1:0]       a_i,
    input  logic [B_W-1:0]       b_i,
    output logic signed [FW-1:0] full_o
);

    logic signed [A_W:0] a_x;
    logic signed [B_W:0] b_x;

    // Extend operands by their own signedness
    always_comb begin
        a_x = {(A_SIGNED ? a_i[A_W-1] : 1'b0), a_i};
        b_x = {(B_SIGNED ? b_i[B_W-1] : 1'b0), b_i};
    end

    // Exact product at full width
    always_comb begin
        full_o = FW'(a_x) * FW'(b_x);
    end

endmodule

// File: rtl/fxp_requant.sv
// Rescales an exact signed product to the output fraction width, rounds,
// checks the output range and applies the chosen overflow handling.
// The overflow decision is taken on the value after rounding.
// Assumes: IN_W carries the exact value; a working width with headroom
// is derived so neither rounding nor up-scaling can overflow internally.
module fxp_requant
    import fxp_mult_pkg::*;
#(
    parameter int        IN_W       = 34,
    parameter int        IN_FRAC    = 16,
    parameter int        OUT_W      = 16,
    parameter int        OUT_FRAC   = 8,
    parameter bit        OUT_SIGNED = 1'b1,
    parameter ovf_mode_e OVF_MODE   = OVF_SAT,
    parameter rnd_mode_e RND_MODE   = RND_HALF_UP
) (
    input  logic signed [IN_W-1:0] val_i,
    output logic [OUT_W-1:0]       val_o,
    output logic                   ovf_o
);

    localparam int DROP    = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
    localparam int GROW    = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;
    localparam int WW      = imax(IN_W + GROW, OUT_W) + 2;
    localparam int HALF_SH = (DROP > 0) ? DROP - 1 : 0;
    localparam logic signed [WW-1:0] ONE  = WW'(1);
    localparam logic signed [WW-1:0] HALF =
        (RND_MODE == RND_HALF_UP && DROP > 0) ? (ONE <<< HALF_SH) : '0;
    localparam logic signed [WW-1:0] MAXV = (ONE <<< (OUT_W - int'(OUT_SIGNED))) - ONE;
    localparam logic signed [WW-1:0] MINV = OUT_SIGNED ? -(ONE <<< (OUT_W - 1)) : '0;

    logic signed [WW-1:0] ext;
    logic signed [WW-1:0] scaled;
    logic                 above;
    logic                 below;

    // Widen, round, and align to the output binary point
    always_comb begin
        ext    = {{(WW - IN_W){val_i[IN_W-1]}}, val_i};
        scaled = ((ext + HALF) >>> DROP) <<< GROW;
    end

    // Range test against the output limits
    always_comb begin
        above = scaled > MAXV;
        below = scaled < MINV;
        ovf_o = above | below;
    end

    // Overflow handling picked by parameter
    generate
        if (OVF_MODE == OVF_SAT) begin : g_sat
            always_comb begin
                if (above)      val_o = MAXV[OUT_W-1:0];
                else if (below) val_o = MINV[OUT_W-1:0];
                else            val_o = scaled[OUT_W-1:0];
            end
        end else begin : g_wrap
            always_comb begin
                val_o = scaled[OUT_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/fxp_pipe.sv
// Chain of N data registers with a valid bit per stage and one common
// advance enable. When en_i is low every stage holds.
// Assumes: N >= 1.
module fxp_pipe #(
    parameter int W = 17,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);

    logic [W-1:0] dat_q [N];
    logic         vld_q [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_head
                // First stage captures the block's new sample
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[i] <= 1'b0;
                        dat_q[i] <= '0;
                    end else if (en_i) begin
                        vld_q[i] <= vld_i;
                        dat_q[i] <= dat_i;
                    end
                end
            end else begin : g_body
                // Later stages take the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[i] <= 1'b0;
                        dat_q[i] <= '0;
                    end else if (en_i) begin
                        vld_q[i] <= vld_q[i-1];
                        dat_q[i] <= dat_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign vld_o = vld_q[N-1];
    assign dat_o = dat_q[N-1];

endmodule

// File: rtl/fxp_hs_mult.sv
// Pipelined fixed-point multiplier with four-wire flow control.
// Datapath: exact multiply -> rescale/round/overflow -> STAGES registers.
// Flow: the register chain advances when out_rdy_i is high; in_rdy_o
// mirrors out_rdy_i, and a sample offered the cycle after in_rdy_o was low
// is discarded. The overflow flag travels with its product.
// Assumes: STAGES >= 1; out_rdy_i tied high when downstream has no stall.
module fxp_hs_mult
    import fxp_mult_pkg::*;
#(
    parameter int        A_W      = 16,
    parameter int        A_IW     = 8,
    parameter bit        A_SIGNED = 1'b1,
    parameter int        B_W      = 16,
    parameter int        B_IW     = 8,
    parameter bit        B_SIGNED = 1'b1,
    parameter int        P_W      = 16,
    parameter int        P_IW     = 8,
    parameter bit        P_SIGNED = 1'b1,
    parameter int        STAGES   = 3,
    parameter ovf_mode_e OVF_MODE = OVF_SAT,
    parameter rnd_mode_e RND_MODE = RND_HALF_UP
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           in_vld_i,
    input  logic           out_rdy_i,
    output logic           in_rdy_o,
    output logic           out_vld_o,
    output logic [P_W-1:0] prod_o,
    output logic           ovf_o
);

    localparam int A_FRAC = A_W - A_IW;
    localparam int B_FRAC = B_W - B_IW;
    localparam int P_FRAC = P_W - P_IW;
    localparam int FW     = A_W + B_W + 2;

    logic signed [FW-1:0] full;
    logic [P_W-1:0]       q_val;
    logic                 q_ovf;
    logic                 rdy_q;
    logic                 accept;
    logic                 last_vld;
    logic [P_W:0]         last_dat;

    fxp_mul_core #(
        .A_W      (A_W),
        .A_SIGNED (A_SIGNED),
        .B_W      (B_W),
        .B_SIGNED (B_SIGNED)
    ) u_core (
        .a_i    (a_i),
        .b_i    (b_i),
        .full_o (full)
    );

    fxp_requant #(
        .IN_W       (FW),
        .IN_FRAC    (A_FRAC + B_FRAC),
        .OUT_W      (P_W),
        .OUT_FRAC   (P_FRAC),
        .OUT_SIGNED (P_SIGNED),
        .OVF_MODE   (OVF_MODE),
        .RND_MODE   (RND_MODE)
    ) u_rq (
        .val_i (full),
        .val_o (q_val),
        .ovf_o (q_ovf)
    );

    // Remember last cycle's readiness for the one-cycle-lag acceptance rule
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b1;
        else        rdy_q <= out_rdy_i;
    end

    // A sample enters only when offered, chain moving, and ready last cycle
    always_comb begin
        accept = in_vld_i & out_rdy_i & rdy_q;
    end

    fxp_pipe #(
        .W (P_W + 1),
        .N (STAGES)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (out_rdy_i),
        .vld_i (accept),
        .dat_i ({q_ovf, q_val}),
        .vld_o (last_vld),
        .dat_o (last_dat)
    );

    // Present the tail stage; valid and flag are masked by downstream ready
    always_comb begin
        in_rdy_o  = out_rdy_i;
        out_vld_o = last_vld & out_rdy_i;
        prod_o    = last_dat[P_W-1:0];
        ovf_o     = last_dat[P_W] & out_vld_o;
    end

endmodule

// File: rtl/fxp_hs_mult_chk.sv
// Port-level properties of the multiplier, bound to every instance.
// Assumes: checked instance uses the same P_W, P_SIGNED and OVF_MODE.
module fxp_hs_mult_chk
    import fxp_mult_pkg::*;
#(
    parameter int        P_W      = 16,
    parameter bit        P_SIGNED = 1'b1,
    parameter ovf_mode_e OVF_MODE = OVF_SAT
) (
    input logic           clk,
    input logic           rst_n,
    input logic           out_rdy_i,
    input logic           out_vld_o,
    input logic [P_W-1:0] prod_o,
    input logic           ovf_o
);

    localparam logic [P_W-1:0] TOP = P_SIGNED ? {1'b0, {(P_W-1){1'b1}}} : {P_W{1'b1}};
    localparam logic [P_W-1:0] BOT = P_SIGNED ? {1'b1, {(P_W-1){1'b0}}} : '0;

    // R7
    stall_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rdy_i |-> !out_vld_o);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rdy_i |=> $stable(prod_o));

    // R5
    ovf_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> out_vld_o);

    // R10
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld_o && !ovf_o));

    generate
        if (OVF_MODE == OVF_SAT) begin : g_sat
            // R3
            sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ovf_o |-> (prod_o == TOP || prod_o == BOT));
        end
    endgenerate

endmodule

bind fxp_hs_mult fxp_hs_mult_chk #(
    .P_W      (P_W),
    .P_SIGNED (P_SIGNED),
    .OVF_MODE (OVF_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_rdy_i (out_rdy_i),
    .out_vld_o (out_vld_o),
    .prod_o    (prod_o),
    .ovf_o     (ovf_o)
);

// File: tb/fxp_hs_mult_tb.sv
`timescale 1ns/1ps
module fxp_hs_mult_tb;
    import fxp_mult_pkg::*;

    localparam int STAGES = 3;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        int          shifts;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        in_vld = 1'b0;
    logic        out_rdy = 1'b1;
    logic        in_rdy, in_rdy_w;
    logic        out_vld, out_vld_w;
    logic [15:0] prod, prod_w;
    logic        ovf, ovf_w;

    int    n_chk = 0;
    int    n_bad = 0;
    int    n_out = 0;
    int    shift_cnt = 0;
    logic  rdy_prev = 1'b1;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    fxp_hs_mult #(.STAGES(STAGES), .OVF_MODE(OVF_SAT), .RND_MODE(RND_HALF_UP)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .in_vld_i(in_vld),
        .out_rdy_i(out_rdy), .in_rdy_o(in_rdy), .out_vld_o(out_vld),
        .prod_o(prod), .ovf_o(ovf));

    fxp_hs_mult #(.STAGES(STAGES), .OVF_MODE(OVF_WRAP), .RND_MODE(RND_TRUNC)) u_dut_wrap (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .in_vld_i(in_vld),
        .out_rdy_i(out_rdy), .in_rdy_o(in_rdy_w), .out_vld_o(out_vld_w),
        .prod_o(prod_w), .ovf_o(ovf_w));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Rescaled Q8.8 value of a*b before range handling
    function automatic longint scaled(input logic [15:0] x, input logic [15:0] y, input bit rnd);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        if (rnd) p = p + 128;
        return p >>> 8;
    endfunction

    function automatic bit out_of_range(input longint v);
        return (v > 32767) || (v < -32768);
    endfunction

    function automatic logic [15:0] sat16(input longint v);
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    // Scoreboard: sampled 1 ns after each falling edge, inputs already settled
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            rdy_prev = out_rdy;
        end else begin
            chk(in_rdy == out_rdy, "R8", "in_rdy_o mirrors out_rdy_i", in_rdy, out_rdy);
            if (!out_rdy)
                chk(!out_vld && !out_vld_w, "R7", "out_vld_o during stall", out_vld, 0);
            chk(out_vld == out_vld_w, "R9", "instances agree on valid", out_vld_w, out_vld);
            if (out_vld) begin
                n_out++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", prod, 0);
                end else begin
                    item_t it;
                    longint vr, vt;
                    it = exp_q.pop_front();
                    vr = scaled(it.a, it.b, 1'b1);
                    vt = scaled(it.a, it.b, 1'b0);
                    chk(shift_cnt - it.shifts == STAGES, "R6", "ready cycles to output",
                        shift_cnt - it.shifts, STAGES);
                    chk(prod == sat16(vr), out_of_range(vr) ? "R3" : "R1",
                        "saturating/rounded product", prod, sat16(vr));
                    chk(prod_w == vt[15:0], out_of_range(vt) ? "R4" : "R2",
                        "wrapping/truncated product", prod_w, vt[15:0]);
                    chk(ovf == out_of_range(vr), "R5", "overflow flag, rounded", ovf, out_of_range(vr));
                    chk(ovf_w == out_of_range(vt), "R5", "overflow flag, truncated", ovf_w, out_of_range(vt));
                end
            end else begin
                chk(!ovf && !ovf_w, "R5", "flag without valid", ovf, 0);
            end
            if (in_vld && out_rdy && rdy_prev)
                exp_q.push_back('{a: a, b: b, shifts: shift_cnt});
            if (out_rdy) shift_cnt++;
            rdy_prev = out_rdy;
        end
    end

    task automatic drive(input logic v, input logic [15:0] x, input logic [15:0] y, input logic r);
        @(negedge clk);
        in_vld  = v;
        a       = x;
        b       = y;
        out_rdy = r;
    endtask

    task automatic drain();
        for (int i = 0; i < STAGES + 4; i++) drive(1'b0, 16'h0, 16'h0, 1'b1);
        @(negedge clk); #2;
        chk(exp_q.size() == 0, "R9", "results outstanding after drain", exp_q.size(), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #2;
        chk(!out_vld && !out_vld_w, "R10", "valid in reset", out_vld, 0);
        chk(!ovf && !ovf_w, "R10", "flag in reset", ovf, 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(!out_vld && !ovf, "R10", "first cycle after reset", out_vld, 0);
    endtask

    task automatic t_values();   // R1 R2 main function
        drive(1'b1, 16'h0180, 16'h0200, 1'b1);   //  1.5 * 2.0
        drive(1'b1, 16'hFE80, 16'h0300, 1'b1);   // -1.5 * 3.0
        drive(1'b1, 16'h0040, 16'hFFC0, 1'b1);   // 0.25 * -0.25
        drive(1'b1, 16'h0AAA, 16'h0555, 1'b1);
        drain();
    endtask

    task automatic t_round();    // R1 R2 half-LSB and sign cases
        drive(1'b1, 16'h0001, 16'h0080, 1'b1);   // +half LSB: round 1, trunc 0
        drive(1'b1, 16'hFFFF, 16'h0080, 1'b1);   // -half LSB: round 0, trunc -1
        drive(1'b1, 16'h0001, 16'h007F, 1'b1);   // below half
        drive(1'b1, 16'hFFFF, 16'h0081, 1'b1);   // just over -half
        drain();
    endtask

    task automatic t_ovf();      // R3 R4 R5 range edges
        drive(1'b1, 16'h7F00, 16'h0200, 1'b1);   // 254 -> clamp high / wrap
        drive(1'b1, 16'h8000, 16'h8000, 1'b1);   // +16384
        drive(1'b1, 16'h8000, 16'h0200, 1'b1);   // -256 -> clamp low
        drive(1'b1, 16'h8000, 16'h0100, 1'b1);   // exactly -128, in range
        drive(1'b1, 16'h7FFF, 16'h0100, 1'b1);   // exactly max, in range
        drive(1'b1, 16'h7FFF, 16'h0101, 1'b1);   // just over max
        drain();
    endtask

    task automatic t_latency();  // R6 explicit count under steady ready
        int n;
        drive(1'b1, 16'h0300, 16'h0100, 1'b1);
        n = 0;
        drive(1'b0, 16'h0, 16'h0, 1'b1);
        #2;
        while (!out_vld && n < 20) begin
            n++;
            drive(1'b0, 16'h0, 16'h0, 1'b1);
            #2;
        end
        chk(n + 1 == STAGES, "R6", "cycles from accept to valid", n + 1, STAGES);
        drain();
    endtask

    task automatic t_stall();    // R7 hold contents, lose nothing
        int base;
        logic [15:0] held;
        base = n_out;
        drive(1'b1, 16'h0100, 16'h0100, 1'b1);
        drive(1'b1, 16'h0200, 16'h0100, 1'b1);
        drive(1'b1, 16'h0300, 16'h0100, 1'b1);
        drive(1'b1, 16'h0400, 16'h0100, 1'b0);   // offered during stall: dropped
        #2; held = prod;
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 16'h0, 16'h0, 1'b0);
            #2;
            chk(prod == held, "R7", "product held during stall", prod, held);
        end
        drain();
        chk(n_out - base == 3, "R7", "results after stall", n_out - base, 3);
    endtask

    task automatic t_drop();     // R8 one-cycle lag on readiness
        int base;
        base = n_out;
        drive(1'b1, 16'h1100, 16'h0100, 1'b0);   // ready low: dropped
        drive(1'b1, 16'h2200, 16'h0100, 1'b1);   // lag cycle: dropped
        drive(1'b1, 16'h0500, 16'h0100, 1'b1);   // accepted
        drain();
        chk(n_out - base == 1, "R8", "samples taken around low ready", n_out - base, 1);
    endtask

    task automatic t_random();   // R9 ordering under mixed traffic
        for (int i = 0; i < 400; i++)
            drive(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                  ($urandom_range(0, 3) != 0));
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_values();
        t_round();
        t_ovf();
        t_latency();
        t_stall();
        t_drop();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule